// File: doc/BRIEF.md
# Serial EEPROM Command Shifter

This block is the host side of a three-wire serial configuration EEPROM link. A request carries an operation (read, write or erase), a 6-bit word address and, for a write, a 16-bit data word. The block packs the request into one fixed 27-bit serial frame. It drives chip select and the shift clock at a half-period set by a parameter, and shifts the frame out most significant bit first on the data-in line. During a read it collects the 16 bits the EEPROM returns.

The serial outputs form one control field. Bit 0 is data-in to the EEPROM, bit 1 is chip select and bit 2 is the shift clock. Data-out from the EEPROM, which sits at bit 3 of that field, arrives on its own input. A request is taken only while the block is idle. Completion is marked by a one-cycle done pulse. The last read word stays on a 16-bit result output until the next read finishes.

Top module: `ee_cmd_shifter`

## Requirements
- R1: The frame is 27 bits long and is sent MSB first. Frame bit 26 is a 1. Bits 25:24 hold the opcode: write 01, read 10, erase 11. Bits 23:18 hold the address and bit 17 is 0. Bits 16:1 hold the write data, or zero for a read or an erase. Bit 0 is 0.
- R2: Pin mapping on `ser_ctrl`: bit 0 is data-in to the EEPROM, bit 1 is chip select and bit 2 is the shift clock. All three are 0 while chip select is low.
- R3: Data-in is constant while the shift clock is high. It changes only when the clock is low, and the EEPROM takes it on each rising edge.
- R4: Each low and each high clock phase lasts `HALF_CYC` clock cycles. The first rising edge comes `HALF_CYC` cycles after chip select rises.
- R5: Chip select falls `HALF_CYC` cycles after the last falling clock edge. It stays low for at least `HALF_CYC` cycles before it rises again. The clock is never high while chip select is low.
- R6: For a read, `ser_dout` is sampled at the rising edges of frame positions 16 down to 1 (the 11th through 26th bits sent). These samples form `rd_data` MSB first, and `rd_data` updates together with the done pulse. Values on `ser_dout` at any other edge have no effect.
- R7: Write and erase commands leave `rd_data` unchanged.
- R8: `done` is high for exactly one cycle. That cycle follows the 56*`HALF_CYC` cycles that come after the accepting clock edge. `busy` is high from the accepting edge until `done`.
- R9: A request made while `busy` is high is ignored. A request with opcode 00 is ignored.
- R10: After reset, `ser_ctrl` is 0, `done` is 0, `busy` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | Opcode: 01 write, 10 read, 11 erase |
| req_addr | input | 6 | EEPROM word address |
| req_wdata | input | 16 | Write data |
| ser_dout | input | 1 | Data-out from the EEPROM |
| ser_ctrl | output | 3 | Bit 0 data-in, bit 1 chip select, bit 2 shift clock |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Result of the last read |

## Verification
The hardest case to reach from the ports is a request that arrives while a frame is already being shifted. If that request were taken, it would corrupt the frame only partway through. The stimulus therefore injects stray requests with random fields partway through many commands. The bench's EEPROM model then rebuilds every frame from the clock edges and compares it whole. The model also drives data-out high outside the 16 read slots. Any sample taken at a wrong edge shows up in the result word.

// File: rtl/ee_shift_pkg.sv
package ee_shift_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } ee_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_GAP
  } ee_state_e;

  // True when a frame index falls inside the returned-data window.
  function automatic logic in_window(int unsigned idx, int unsigned first, int unsigned width);
    return (idx >= first) && (idx < first + width);
  endfunction
endpackage

// File: rtl/ee_half_timer.sv
module ee_half_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assert_phase_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (cnt != '0) || !run);
endmodule

// File: rtl/ee_frame_shift.sv
module ee_frame_shift
  import ee_shift_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  ee_op_e            op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              shift,
  output logic              bit_out,
  output logic [$clog2(3+ADDR_W+1+DATA_W+1)-1:0] bit_idx,
  output logic              last_bit
);
  localparam int FRAME_LEN = 3 + ADDR_W + 1 + DATA_W + 1;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] shreg;

  function automatic logic [FRAME_LEN-1:0] build(ee_op_e o, logic [ADDR_W-1:0] a,
                                                 logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] payload;
    payload = (o == OP_WRITE) ? d : '0;
    return {1'b1, o, a, 1'b0, payload, 1'b0};
  endfunction

  assign bit_out  = shreg[FRAME_LEN-1];
  assign last_bit = (bit_idx == IDX_W'(FRAME_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_idx <= '0;
    end else if (load) begin
      shreg   <= build(op, addr, wdata);
      bit_idx <= '0;
    end else if (shift) begin
      shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
      bit_idx <= bit_idx + 1'b1;
    end
  end

  assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx < IDX_W'(FRAME_LEN));
endmodule

// File: rtl/ee_read_capture.sv
module ee_read_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              din,
  input  logic              commit,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      rd_data <= '0;
    end else begin
      if (clear)       sh <= '0;
      else if (sample) sh <= {sh[DATA_W-2:0], din};
      if (commit)      rd_data <= sh;
    end
  end

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable(rd_data));
endmodule

// File: rtl/ee_cmd_shifter.sv
module ee_cmd_shifter
  import ee_shift_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ser_dout,
  output logic [2:0]        ser_ctrl,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FRAME_LEN  = 3 + ADDR_W + 1 + DATA_W + 1;
  localparam int IDX_W      = $clog2(FRAME_LEN);
  localparam int DATA_FIRST = 3 + ADDR_W + 1;

  ee_state_e        state;
  ee_op_e           op_q;
  logic             tick;
  logic             accept;
  logic             shift_bit;
  logic             sample_bit;
  logic             finish;
  logic             frame_bit;
  logic             last_bit;
  logic [IDX_W-1:0] bit_idx;
  logic             cs, sck, di;

  assign accept     = (state == ST_IDLE) && req_valid && (ee_op_e'(req_op) != OP_NONE);
  assign shift_bit  = (state == ST_HIGH) && tick && !last_bit;
  assign sample_bit = (state == ST_LOW) && tick && (op_q == OP_READ)
                      && in_window(int'(bit_idx), DATA_FIRST, DATA_W);
  assign finish     = (state == ST_GAP) && tick;

  assign busy = (state != ST_IDLE);
  assign cs   = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_HOLD);
  assign sck  = (state == ST_HIGH);
  assign di   = cs && frame_bit;
  assign ser_ctrl = {sck, cs, di};

  ee_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  ee_frame_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(accept), .op(ee_op_e'(req_op)),
    .addr(req_addr), .wdata(req_wdata), .shift(shift_bit),
    .bit_out(frame_bit), .bit_idx(bit_idx), .last_bit(last_bit)
  );

  ee_read_capture #(.DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(sample_bit),
    .din(ser_dout), .commit(finish && (op_q == OP_READ)), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= OP_NONE;
      done  <= 1'b0;
    end else begin
      done <= finish;
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_LOW;
          op_q  <= ee_op_e'(req_op);
        end
        ST_LOW:  if (tick) state <= ST_HIGH;
        ST_HIGH: if (tick) state <= last_bit ? ST_HOLD : ST_LOW;
        ST_HOLD: if (tick) state <= ST_GAP;
        ST_GAP:  if (tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_clk_needs_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_ctrl[2] |-> ser_ctrl[1]);

  assert_di_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_ctrl[2] && $past(ser_ctrl[2])) |-> $stable(ser_ctrl[0]));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(op_q));
endmodule

// File: tb/tb_ee_cmd_shifter.sv
module tb_ee_cmd_shifter;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        ser_dout = 1'b0;
  logic [2:0]  ser_ctrl;
  logic        busy, done;
  logic [15:0] rd_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ee_cmd_shifter #(.HALF_CYC(H), .ADDR_W(6), .DATA_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .ser_dout(ser_dout),
    .ser_ctrl(ser_ctrl), .busy(busy), .done(done), .rd_data(rd_data)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [26:0] exp_frame(logic [1:0] op, logic [5:0] a, logic [15:0] d);
    logic [26:0] f;
    f = '0;
    f[26] = 1'b1;
    f[25:24] = op;
    f[23:18] = a;
    if (op == 2'b01) f[16:1] = d;
    return f;
  endfunction

  // EEPROM model and pin monitor
  logic [15:0] mword = '0;
  logic [26:0] cap = '0;
  int nbits = 0, cyc = 0;
  int cs_rise_c = -1, cs_fall_c = -1, sck_rise_c = -1, sck_fall_c = -1;
  logic p_sck = 0, p_cs = 0, p_di = 0;

  always @(negedge clk) begin
    logic s, c, d;
    cyc++;
    d = ser_ctrl[0]; c = ser_ctrl[1]; s = ser_ctrl[2];
    if (rst_n) begin
      if (!c && (s || d)) chk(0, "R2 idle pins", ser_ctrl, 0);
      if (c && !p_cs) begin
        if (cs_fall_c >= 0) chk(cyc - cs_fall_c >= H, "R5 cs low gap", cyc - cs_fall_c, H);
        cs_rise_c = cyc; nbits = 0; cap = '0; sck_rise_c = -1;
        ser_dout = 1'b1;
      end
      if (!c && p_cs) begin
        cs_fall_c = cyc;
        chk(cyc - sck_fall_c == H, "R5 cs fall delay", cyc - sck_fall_c, H);
      end
      if (s && p_sck && d != p_di) chk(0, "R3 di moved while clock high", d, p_di);
      if (s && !p_sck) begin
        if (sck_rise_c < 0) chk(cyc - cs_rise_c == H, "R4 first edge", cyc - cs_rise_c, H);
        else chk(cyc - sck_rise_c == 2*H, "R4 clock period", cyc - sck_rise_c, 2*H);
        sck_rise_c = cyc;
        cap = {cap[25:0], d};
        nbits++;
      end
      if (!s && p_sck) begin
        sck_fall_c = cyc;
        if (nbits >= 10 && nbits <= 25) ser_dout = mword[25 - nbits];
        else ser_dout = 1'b1;
      end
    end
    p_sck = s; p_cs = c; p_di = d;
  end

  logic [15:0] exp_rd = '0;

  task automatic run_cmd(logic [1:0] op, logic [5:0] a, logic [15:0] d,
                         logic [15:0] w, bit poke);
    int n;
    mword = w;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_op = $urandom; req_addr = $urandom; req_wdata = $urandom;
    n = 1;
    chk(busy, "R8 busy after accept", busy, 1);
    while (!done && n < 2000) begin
      @(negedge clk); n++;
      if (poke && n == 20) begin
        req_valid = 1; req_op = 2'b01 + 2'($urandom % 3);
      end
      if (n == 21) req_valid = 0;
    end
    chk(n == 56*H + 1, "R8 done latency", n, 56*H + 1);
    chk(!busy, "R8 busy clear at done", busy, 0);
    chk(nbits == 27, "R1 frame length", nbits, 27);
    chk(cap == exp_frame(op, a, d), poke ? "R9 frame intact with stray request" : "R1 frame bits",
        cap, exp_frame(op, a, d));
    if (op == 2'b10) begin
      exp_rd = w;
      chk(rd_data == exp_rd, "R6 read result", rd_data, exp_rd);
    end else
      chk(rd_data == exp_rd, "R7 result kept", rd_data, exp_rd);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    chk(!busy && ser_ctrl == 0, poke ? "R9 no second command" : "R5 idle after done", ser_ctrl, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(ser_ctrl == 0, "R10 pins at reset", ser_ctrl, 0);
    chk(!done && !busy, "R10 flags at reset", {done, busy}, 0);
    chk(rd_data == 0, "R10 result at reset", rd_data, 0);
    rst_n = 1;
    @(negedge clk);
    // opcode 00 is ignored
    req_valid = 1; req_op = 2'b00; req_addr = 6'h15;
    @(negedge clk); req_valid = 0;
    repeat (2*H) begin
      @(negedge clk);
      chk(!busy && ser_ctrl == 0, "R9 null opcode ignored", ser_ctrl, 0);
    end
    // directed corners
    run_cmd(2'b10, 6'h3F, 16'h0000, 16'h8001, 0);
    run_cmd(2'b01, 6'h00, 16'hFFFF, 16'h1234, 0);
    run_cmd(2'b11, 6'h2A, 16'hBEEF, 16'hFFFF, 0);
    run_cmd(2'b10, 6'h01, 16'h0000, 16'h0000, 1);
    run_cmd(2'b10, 6'h10, 16'h0000, 16'hFFFF, 0);
    // random traffic
    for (int i = 0; i < 24; i++) begin
      run_cmd(2'b01 + 2'($urandom % 3), 6'($urandom), 16'($urandom), 16'($urandom), (i % 4) == 1);
    end
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule